// File: doc/BRIEF.md
# DMX512 Channel Receiver

This block listens to a DMX512 lighting control line after the differential line receiver. It finds the long low level that opens every packet, reads the start code and each following slot as an asynchronous byte, and counts slots so that it can pick out a run of `NCH` consecutive channel values. The run begins at the channel number given on `start_addr`.

Values are collected in shadow registers while the packet arrives. They reach the output bank only when the packet has ended cleanly, and that end is marked by the next break. Each update is signalled by a single-cycle strobe. The block drops a packet that contains a framing fault, ignores packets with a non-zero start code, and raises a flag when no valid packet has been applied for a programmable time.

The controlling state machine has six states:
- `ST_IDLE`: after reset, waiting for the first break.
- `ST_BREAK`: the line is held low in a break.
- `ST_MAB`: the mark after break, waiting for the start code.
- `ST_SLOTS`: receiving the channel slots.
- `ST_CHECK`: a slot failed with all bits low, so it may be the next break.
- `ST_DROP`: the packet is discarded until the next break.

Its transitions are:
- From `ST_IDLE`, a break leads to `ST_BREAK`.
- From `ST_BREAK`, the line returning high leads to `ST_MAB`.
- In `ST_MAB`, a start code of zero leads to `ST_SLOTS`. A non-zero start code leads to `ST_DROP`.
- From `ST_MAB` or `ST_SLOTS`, a slot that fails with all bits low leads to `ST_CHECK`. Any other framing fault leads to `ST_DROP`.
- In `ST_CHECK`, a break leads to `ST_BREAK` and commits the packet. The line going high first leads to `ST_DROP`.
- From any other state, a break leads to `ST_BREAK`.

Top module: `dmx_rx_extract`

## Requirements
- R1: A low on `dmx_in` lasting at least 22 bit times (`BRK_CYC` clocks) is a break. A shorter low is treated as data: inside a packet it is a framing fault that drops the packet.
- R2: A mark after break as short as one bit time is accepted, and the start code that follows it is received.
- R3: A slot is one low start bit, 8 data bits sent least significant bit first, and two high stop bits, each `CLK_HZ/BAUD` clocks long. Sampling re-aligns on the falling edge of every start bit, so idle gaps of any length between slots are tolerated.
- R4: Slot 0 is the start code. Output channel k (byte k of `chan_out`, bits 8k+7..8k) takes the value of slot number base+k. Here base is `start_addr` clamped to the range 1..512: 0 reads as 1, and anything above 512 reads as 512.
- R5: A stop bit sampled low discards the whole packet, so no output changes at the next break. Each such packet gives one single-cycle `frame_err` pulse.
- R6: A packet whose start code is not 0 changes no output and gives no `upd` pulse.
- R7: A clean start-code-0 packet is applied when the next break is detected. `upd` is high for exactly one cycle, the cycle after `BRK_CYC`+1 rising edges have passed since the first edge that saw the low pin, and outputs change only together with `upd`.
- R8: Channels whose slot numbers lie beyond the end of a shorter packet keep their previous values. The channels that did arrive are still updated.
- R9: `sig_lost` rises once `LOSS_CYC` clocks pass without an applied packet, and it clears in the same cycle as the next `upd`.
- R10: After reset all channel outputs are 0, and `upd`, `frame_err` and `sig_lost` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dmx_in | input | 1 | Serial line from the line receiver, idle high |
| start_addr | input | 10 | First channel number to extract (1..512) |
| chan_out | output | NCH*8 | Extracted channel values, channel k in byte k |
| upd | output | 1 | One-cycle strobe when `chan_out` is refreshed |
| frame_err | output | 1 | One-cycle pulse when a packet is dropped for framing |
| sig_lost | output | 1 | No packet applied for `LOSS_CYC` clocks |

## Verification
The strobe that applies a packet is due a fixed number of cycles after the pin drops for the closing break: two synchronizer flops, `BRK_CYC` counted low cycles and one output register. The bench stamps the cycle at which it drives the break and the cycle at which it first sees `upd` at a falling edge, and requires a gap of exactly `BRK_CYC`+2. All other checks run after the 25-bit break has finished, well past that point, so the output bank is settled when it is read. Loss of signal is checked 30 cycles before and 30 cycles after the `LOSS_CYC` deadline, counted from the last strobe.

// File: rtl/dmx_rx_pkg.sv
package dmx_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_MAB,
        ST_SLOTS,
        ST_CHECK,
        ST_DROP
    } rx_state_t;

    // Break threshold in bit times (88 us at 4 us per bit)
    localparam int BRK_BITS = 22;
    // Highest channel number in one universe
    localparam int SLOT_MAX = 512;

endpackage

// File: rtl/dmx_rx_sync.sv
module dmx_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/dmx_rx_brkdet.sv
module dmx_rx_brkdet #(
    parameter int BRK_CYC = 4400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_s,
    output logic brk_hit
);
    localparam int CW = $clog2(BRK_CYC + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        low_cnt <= '0;
        else if (rx_s)                     low_cnt <= '0;
        else if (low_cnt != CW'(BRK_CYC))  low_cnt <= low_cnt + 1'b1;
    end

    assign brk_hit = !rx_s && (low_cnt == CW'(BRK_CYC - 1));
endmodule

// File: rtl/dmx_rx_slot.sv
module dmx_rx_slot #(
    parameter int CPB = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       rx_s,
    output logic       slot_ok,
    output logic       slot_err,
    output logic       slot_brk,
    output logic [7:0] slot_data
);
    localparam int HALF = CPB / 2;
    localparam int CW   = $clog2(CPB);

    logic          busy;
    logic          prev;
    logic [CW-1:0] cnt;
    logic [3:0]    bitn;
    logic [7:0]    sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            prev     <= 1'b1;
            cnt      <= '0;
            bitn     <= '0;
            sr       <= '0;
            slot_ok  <= 1'b0;
            slot_err <= 1'b0;
            slot_brk <= 1'b0;
        end else begin
            prev     <= rx_s;
            slot_ok  <= 1'b0;
            slot_err <= 1'b0;
            slot_brk <= 1'b0;
            if (!en) begin
                busy <= 1'b0;
            end else if (!busy) begin
                if (prev && !rx_s) begin
                    busy <= 1'b1;
                    cnt  <= CW'(HALF - 1);
                    bitn <= '0;
                end
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                cnt  <= CW'(CPB - 1);
                bitn <= bitn + 1'b1;
                case (bitn)
                    4'd0: if (rx_s) busy <= 1'b0;
                    4'd9: begin
                        if (!rx_s) begin
                            slot_err <= 1'b1;
                            slot_brk <= (sr == 8'h00);
                            busy     <= 1'b0;
                        end
                    end
                    4'd10: begin
                        busy <= 1'b0;
                        if (rx_s) slot_ok  <= 1'b1;
                        else      slot_err <= 1'b1;
                    end
                    default: sr <= {rx_s, sr[7:1]};
                endcase
            end
        end
    end

    assign slot_data = sr;
endmodule

// File: rtl/dmx_rx_extract.sv
module dmx_rx_extract
    import dmx_rx_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int BAUD     = 250_000,
    parameter int NCH      = 4,
    parameter int LOSS_CYC = 50_000_000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dmx_in,
    input  logic [9:0]     start_addr,
    output logic [NCH*8-1:0] chan_out,
    output logic           upd,
    output logic           frame_err,
    output logic           sig_lost
);
    localparam int CPB     = CLK_HZ / BAUD;
    localparam int BRK_CYC = BRK_BITS * CPB;
    localparam int LW      = $clog2(LOSS_CYC + 1);
    localparam int IW      = 11;

    logic       rx_s;
    logic       brk_hit;
    logic       slot_ok, slot_err, slot_brk;
    logic [7:0] slot_data;
    logic       slot_en;

    rx_state_t  state, nxt;
    logic [9:0] base;
    logic [IW-1:0] slot_idx;
    logic       pkt_ok;
    logic       commit, ferr;
    logic [LW-1:0] loss_cnt;
    logic [NCH-1:0] hit, got;

    dmx_rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(dmx_in), .dout(rx_s)
    );

    dmx_rx_brkdet #(.BRK_CYC(BRK_CYC)) u_brk (
        .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .brk_hit(brk_hit)
    );

    assign slot_en = (state == ST_MAB) || (state == ST_SLOTS);

    dmx_rx_slot #(.CPB(CPB)) u_slot (
        .clk(clk), .rst_n(rst_n), .en(slot_en), .rx_s(rx_s),
        .slot_ok(slot_ok), .slot_err(slot_err), .slot_brk(slot_brk),
        .slot_data(slot_data)
    );

    always_comb begin
        if (start_addr == 10'd0)                 base = 10'd1;
        else if (start_addr > 10'(SLOT_MAX))     base = 10'(SLOT_MAX);
        else                                     base = start_addr;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (brk_hit) nxt = ST_BREAK;
            ST_BREAK: if (rx_s)    nxt = ST_MAB;
            ST_MAB: begin
                if (brk_hit)       nxt = ST_BREAK;
                else if (slot_ok)  nxt = (slot_data == 8'h00) ? ST_SLOTS : ST_DROP;
                else if (slot_err) nxt = slot_brk ? ST_CHECK : ST_DROP;
            end
            ST_SLOTS: begin
                if (brk_hit)       nxt = ST_BREAK;
                else if (slot_err) nxt = slot_brk ? ST_CHECK : ST_DROP;
            end
            ST_CHECK: begin
                if (brk_hit)       nxt = ST_BREAK;
                else if (rx_s)     nxt = ST_DROP;
            end
            ST_DROP:  if (brk_hit) nxt = ST_BREAK;
            default:               nxt = ST_IDLE;
        endcase
    end

    assign commit = brk_hit && pkt_ok &&
                    ((state == ST_SLOTS) || (state == ST_CHECK));
    assign ferr   = (slot_en && slot_err && !slot_brk) ||
                    ((state == ST_CHECK) && rx_s && !brk_hit);

    // Per-channel shadow and output registers
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [7:0] shadow_q;
        logic [7:0] out_q;

        assign hit[i] = slot_ok && (state == ST_SLOTS) &&
                        (slot_idx == (IW'(base) + IW'(i)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= '0;
                got[i]   <= 1'b0;
                out_q    <= '0;
            end else begin
                if (hit[i]) begin
                    shadow_q <= slot_data;
                    got[i]   <= 1'b1;
                end else if ((state == ST_BREAK) && rx_s) begin
                    got[i]   <= 1'b0;
                end
                if (commit && got[i]) out_q <= shadow_q;
            end
        end

        assign chan_out[i*8 +: 8] = out_q;
    end

    // Outputs, slot counting and loss timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd       <= 1'b0;
            frame_err <= 1'b0;
            pkt_ok    <= 1'b0;
            slot_idx  <= '0;
            loss_cnt  <= '0;
            sig_lost  <= 1'b0;
        end else begin
            upd       <= commit;
            frame_err <= ferr;

            if ((state == ST_BREAK) && rx_s) begin
                pkt_ok   <= 1'b0;
                slot_idx <= '0;
            end else if ((state == ST_MAB) && !brk_hit && slot_ok &&
                         (slot_data == 8'h00)) begin
                pkt_ok   <= 1'b1;
                slot_idx <= IW'(1);
            end else if ((state == ST_SLOTS) && slot_ok &&
                         (slot_idx != IW'(SLOT_MAX + 1))) begin
                slot_idx <= slot_idx + 1'b1;
            end

            if (commit) begin
                loss_cnt <= '0;
                sig_lost <= 1'b0;
            end else if (loss_cnt == LW'(LOSS_CYC - 1)) begin
                sig_lost <= 1'b1;
            end else begin
                loss_cnt <= loss_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dmx_rx_extract_chk.sv
module dmx_rx_extract_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH*8-1:0] chan_out,
    input logic           upd,
    input logic           frame_err,
    input logic           sig_lost
);
    // R7: update strobe lasts one cycle
    a_r7_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

    // R7: the output bank moves only together with the strobe
    a_r7_out_with_upd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_out) |-> upd);

    // R9: an applied packet clears the loss flag
    a_r9_lost_clear: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> !sig_lost);

    // R5: a dropped packet is never applied in the same cycle
    a_r5_err_no_upd: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !upd);

    // R5: one pulse per dropped packet
    a_r5_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);
endmodule

bind dmx_rx_extract dmx_rx_extract_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_out(chan_out),
    .upd(upd), .frame_err(frame_err), .sig_lost(sig_lost)
);

// File: tb/tb_dmx_rx_extract.sv
module tb_dmx_rx_extract;
    localparam int CLK_HZ   = 2_000_000;
    localparam int BAUD     = 250_000;
    localparam int NCH      = 3;
    localparam int LOSS_CYC = 20000;
    localparam int CPB      = CLK_HZ / BAUD;
    localparam int BRK_CYC  = 22 * CPB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic [9:0] addr = 10'd1;
    logic [NCH*8-1:0] chan;
    logic upd, ferr, lost;

    int tests = 0, fails = 0;
    int cyc = 0, brk_cyc = 0, upd_cyc = 0;
    int upd_cnt = 0, err_cnt = 0;
    int exp_upd = 0, exp_err = 0;
    logic [7:0] expv [NCH];

    always #10 clk = ~clk;

    dmx_rx_extract #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .NCH(NCH), .LOSS_CYC(LOSS_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .dmx_in(rx), .start_addr(addr),
        .chan_out(chan), .upd(upd), .frame_err(ferr), .sig_lost(lost)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (upd) begin upd_cnt++; upd_cyc = cyc; end
        if (ferr) err_cnt++;
    end

    always @(negedge clk) begin
        if (cyc > 190000) begin
            fails++; tests++;
            $display("FAIL watchdog: actual cycle %0d, expected end before 190000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [7:0] val(int seed, int n);
        return 8'(seed * 37 + n * 11 + 5);
    endfunction

    task automatic chk(int act, int exp, string req);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(logic lvl, int n);
        rx = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic slot(logic [7:0] d, logic s1, logic s2);
        hold(1'b0, CPB);
        for (int b = 0; b < 8; b++) hold(d[b], CPB);
        hold(s1, CPB);
        hold(s2, CPB);
    endtask

    task automatic brk();
        rx = 1'b0;
        brk_cyc = cyc;
        repeat (25 * CPB) @(negedge clk);
    endtask

    // fault: 0 none, 1 second stop low, 2 first stop low
    task automatic pkt(logic [7:0] sc, int nsl, int seed, int fidx, int fault, int mab);
        hold(1'b1, mab * CPB);
        slot(sc, 1'b1, 1'b1);
        hold(1'b1, seed % 5);
        for (int n = 1; n <= nsl; n++) begin
            slot(val(seed, n), !(n == fidx && fault == 2), !(n == fidx && fault == 1));
            hold(1'b1, (n * 5 + seed) % 7);
        end
        brk();
    endtask

    task automatic model(int nsl, int seed, logic [7:0] sc, bit ok);
        int eff;
        eff = (addr == 0) ? 1 : (addr > 512) ? 512 : int'(addr);
        if (ok && sc == 8'h00) begin
            exp_upd++;
            for (int k = 0; k < NCH; k++)
                if (eff + k <= nsl) expv[k] = val(seed, eff + k);
        end
        if (!ok) exp_err++;
    endtask

    task automatic check_all(string req);
        for (int k = 0; k < NCH; k++) chk(int'(chan[k*8 +: 8]), int'(expv[k]), req);
        chk(upd_cnt, exp_upd, req);
        chk(err_cnt, exp_err, req);
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) expv[k] = 8'h00;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(int'(chan), 0, "R10");
        chk(int'(upd), 0, "R10");
        chk(int'(ferr), 0, "R10");
        chk(int'(lost), 0, "R10");
        rst_n = 1'b1;
        hold(1'b1, 40);
        brk();

        // R3, R4: basic extraction with varied gaps; R7 latency
        addr = 10'd1;
        pkt(8'h00, 6, 3, 0, 0, 2); model(6, 3, 8'h00, 1'b1);
        check_all("R3_R4");
        chk(upd_cyc - brk_cyc, BRK_CYC + 2, "R7");

        // R2: mark after break of one bit time
        addr = 10'd4;
        pkt(8'h00, 8, 9, 0, 0, 1); model(8, 9, 8'h00, 1'b1);
        check_all("R2");

        // R6: non-zero start code
        addr = 10'd2;
        pkt(8'h17, 8, 11, 0, 0, 2);
        check_all("R6");

        // R5: second stop bit low, then first stop bit low
        pkt(8'h00, 8, 13, 3, 1, 2); model(8, 13, 8'h00, 1'b0);
        check_all("R5");
        pkt(8'h00, 8, 14, 2, 2, 2); model(8, 14, 8'h00, 1'b0);
        check_all("R5");

        // R8: short packet
        addr = 10'd5;
        pkt(8'h00, 6, 17, 0, 0, 2); model(6, 17, 8'h00, 1'b1);
        check_all("R8");

        // R1: low of 21 bit times is not a break
        addr = 10'd1;
        hold(1'b1, 2 * CPB);
        slot(8'h00, 1'b1, 1'b1);
        for (int n = 1; n <= 3; n++) slot(val(19, n), 1'b1, 1'b1);
        hold(1'b0, 21 * CPB);
        hold(1'b1, 40);
        for (int n = 4; n <= 6; n++) slot(val(19, n), 1'b1, 1'b1);
        brk();
        exp_err++;
        check_all("R1");
        // R1: 25 bit low was a break: the next packet lands
        pkt(8'h00, 5, 21, 0, 0, 2); model(5, 21, 8'h00, 1'b1);
        check_all("R1");

        // R4: clamp of address 0
        addr = 10'd0;
        pkt(8'h00, 4, 23, 0, 0, 2); model(4, 23, 8'h00, 1'b1);
        check_all("R4");

        // R4 sweep of start addresses
        for (int a = 1; a <= 8; a++) begin
            addr = 10'(a);
            pkt(8'h00, 10, a + 30, 0, 0, 1 + (a % 3)); model(10, a + 30, 8'h00, 1'b1);
            check_all("R4");
        end

        // R4, R8: address above 512 with a full universe
        addr = 10'd1023;
        pkt(8'h00, 512, 41, 0, 0, 2); model(512, 41, 8'h00, 1'b1);
        check_all("R4_R8");
        chk(int'(lost), 0, "R9");

        // R9: loss flag timing
        hold(1'b1, 8);
        while (cyc < upd_cyc + LOSS_CYC - 30) @(negedge clk);
        chk(int'(lost), 0, "R9");
        while (cyc < upd_cyc + LOSS_CYC + 30) @(negedge clk);
        chk(int'(lost), 1, "R9");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule